// File: doc/BRIEF.md
# Descriptor Ring DMA Sequencer

This block sequences one audio channel through a circular list of 32 buffer descriptors held in system memory. Each descriptor is 8 bytes long and holds a buffer address and a control word. The sequencer reads a descriptor one word at a time through a simple request/valid port. It then hands the buffer address to the audio datapath, which pulls 16-bit samples and pulses a take strobe for each one. The sequencer counts the samples left in the buffer and moves to the next descriptor when the count reaches zero. At the end of a buffer it can raise a completion event. When it reaches the host-programmed last valid entry, it stops.

The host has three write strobes: ring base, last valid index, and run. Run is stored as written. Writing 1 to run starts the channel at the prefetch index, including when the channel is already running. Writing 0 to run stops the channel. While the channel is halted, a new last valid index restarts it if run is still set. This lets software append buffers without a full restart. While halted with run set, the channel supplies fill data to the datapath. The fill data is zero, or the final sample of the last buffer if that descriptor asked to hold it.

The control machine has four states. **IDLE** waits for a host start. **FETCH_ADDR** reads descriptor word 0. **FETCH_CTL** reads descriptor word 1. **STREAM** counts samples.

The transitions are:
- *Start*: a run write of 1, or a last-index write while halted with run set, advances the indices and goes to FETCH_ADDR from any state.
- *Stop*: a run write of 0 goes to IDLE from any state.
- *Addr-loaded*: FETCH_ADDR goes to FETCH_CTL on read data.
- *Ctl-loaded*: FETCH_CTL goes to STREAM when the length is nonzero.
- *Skip*: FETCH_CTL with a zero length, when not at the last index, advances and goes to FETCH_ADDR.
- *Empty-end*: FETCH_CTL with a zero length at the last index goes to IDLE and halts.
- *Next*: STREAM, on the final sample when not at the last index, advances and goes to FETCH_ADDR.
- *Ring-end*: STREAM, on the final sample at the last index, goes to IDLE, halts and sets the last-buffer flag.

Top module: `desc_ring_seq`

## Requirements
- R1: After reset the channel is halted, run is clear, and the current, prefetch and last indices are 0. No memory request, sample ready or fill is active.
- R2: A base write keeps only bits 31:2 and forces bits 1:0 to 0. A last-index write stores the written value modulo 32. The descriptor for index i is word 0 at base+8i, then word 1 at base+8i+4.
- R3: A run write of 1 sets current to prefetch, increments prefetch, clears halted and starts a fetch. A run write of 0 sets halted and ends any fetch or stream. A run write takes priority over a last-index write in the same cycle.
- R4: Descriptor word 0, with bits 1:0 cleared, becomes the sample address. Bits 15:0 of word 1 load the remaining count. Sample ready is raised once both words have arrived and the length is nonzero.
- R5: Each accepted sample lowers the remaining count by one and raises the sample address by 2. The remaining count output always shows the live count.
- R6: When the count reaches zero, a one-cycle completion pulse is raised if bit 31 of word 1 was set.
- R7: When the count reaches zero at current == last, a one-cycle last-buffer pulse is raised, halted and the last-buffer flag are set, and streaming stops. Otherwise the indices advance and the next fetch begins.
- R8: A last-index write while run is set and the channel is halted clears halted and the last-buffer flag, advances the indices and fetches. At any other time the write only stores the index.
- R9: A zero-length descriptor advances the indices without streaming. If it is at the last index, the channel instead halts without a last-buffer pulse and with the hold choice cleared.
- R10: Fill is active exactly when run is set and the channel is halted. Fill data is 0, unless the buffer that ended the ring had bit 30 set in word 1. In that case fill data is the last sample accepted.
- R11: The prefetch index wraps from 31 to 0, and the current index follows it through the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | 32 | Ring base value |
| lvi_wr | input | 1 | Last-index write strobe |
| lvi_wdata | input | 8 | Last-index value, kept modulo 32 |
| run_wr | input | 1 | Run write strobe |
| run_wdata | input | 1 | Run value |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid for the requested word |
| mem_rdata | input | 32 | Read data |
| smp_ready | output | 1 | A buffer is live and samples may be taken |
| smp_addr | output | 32 | Byte address of the next sample |
| smp_take | input | 1 | Datapath accepted one sample |
| smp_data | input | 16 | Value of the accepted sample |
| fill_en | output | 1 | Datapath should play fill data |
| fill_data | output | 16 | Fill sample value |
| cur_idx | output | 5 | Current descriptor index |
| pre_idx | output | 5 | Prefetch descriptor index |
| last_idx | output | 5 | Last valid descriptor index |
| remaining | output | 16 | Samples left in the current buffer |
| halted | output | 1 | Channel halted |
| last_flag | output | 1 | The last valid buffer has completed |
| run_active | output | 1 | Stored run bit |
| ioc_evt | output | 1 | Buffer-complete pulse |
| last_evt | output | 1 | Last-buffer-complete pulse |

## Verification
Every internal register of this block is visible at the ports, directly or in the address it drives. A wrong index therefore shows on the next fetch address, one cycle after the advance. A wrong count or address shows on `remaining` and `smp_addr` one cycle after a take.

A wrong stored hold policy or last sample shows only after the ring ends, on `fill_data`. Comparing every output against a reference model on every cycle catches that within one cycle of the halt.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int WORD_W       = 32;
    localparam int CTL_IOC_BIT  = 31;
    localparam int CTL_HOLD_BIT = 30;

    typedef enum logic [1:0] {
        S_IDLE       = 2'd0,
        S_FETCH_ADDR = 2'd1,
        S_FETCH_CTL  = 2'd2,
        S_STREAM     = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ring_ptrs.sv
module ring_ptrs #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             lvi_we,
    input  logic [IDX_W-1:0] lvi_val,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] pre_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic             cur_is_last
);
    logic [IDX_W-1:0] cur_q, pre_q, last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            pre_q  <= '0;
            last_q <= '0;
        end else begin
            if (adv) begin
                cur_q <= pre_q;
                pre_q <= pre_q + 1'b1;
            end
            if (lvi_we) begin
                last_q <= lvi_val;
            end
        end
    end

    assign cur_idx     = cur_q;
    assign pre_idx     = pre_q;
    assign last_idx    = last_q;
    assign cur_is_last = (cur_q == last_q);

    // R11: current follows prefetch through the wrap
    assert_adv_takes_pre_R11: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (cur_idx == $past(pre_idx)));
    // R2: last index stored as written (already truncated)
    assert_lvi_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lvi_we |=> (last_idx == $past(lvi_val)));
endmodule

// File: rtl/buf_tracker.sv
module buf_tracker #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic [AW-1:0] ld_addr_val,
    input  logic          ld_len,
    input  logic [LW-1:0] ld_len_val,
    input  logic          take,
    output logic [LW-1:0] rem,
    output logic [AW-1:0] baddr,
    output logic          final_take
);
    localparam logic [AW-1:0] SMP_BYTES = AW'(2);

    logic [LW-1:0] rem_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            addr_q <= '0;
        end else begin
            if (ld_addr) begin
                addr_q <= ld_addr_val;
            end else if (take) begin
                addr_q <= addr_q + SMP_BYTES;
            end
            if (ld_len) begin
                rem_q <= ld_len_val;
            end else if (take) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign rem        = rem_q;
    assign baddr      = addr_q;
    assign final_take = take && (rem_q == LW'(1));

    // R5: one sample taken lowers the live count by one
    assert_take_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ld_len) |=> (rem == $past(rem) - 1'b1));
    // R5: never take from an empty buffer
    assert_no_take_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (rem != '0));
endmodule

// File: rtl/fill_gen.sv
module fill_gen #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [SW-1:0] take_data,
    input  logic          arm,
    input  logic          arm_hold,
    input  logic          disarm,
    input  logic          fill_on,
    output logic [SW-1:0] fill_data
);
    logic [SW-1:0] last_q;
    logic          hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            hold_q <= 1'b0;
        end else begin
            if (take) begin
                last_q <= take_data;
            end
            if (arm) begin
                hold_q <= arm_hold;
            end else if (disarm) begin
                hold_q <= 1'b0;
            end
        end
    end

    assign fill_data = (fill_on && hold_q) ? last_q : '0;
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq #(
    parameter int AW    = 32,
    parameter int IDX_W = 5,
    parameter int LW    = 16,
    parameter int SW    = 16,
    parameter int LVI_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      base_wr,
    input  logic [AW-1:0]             base_wdata,
    input  logic                      lvi_wr,
    input  logic [LVI_W-1:0]          lvi_wdata,
    input  logic                      run_wr,
    input  logic                      run_wdata,
    output logic                      mem_req,
    output logic [AW-1:0]             mem_addr,
    input  logic                      mem_rvalid,
    input  logic [seq_pkg::WORD_W-1:0] mem_rdata,
    output logic                      smp_ready,
    output logic [AW-1:0]             smp_addr,
    input  logic                      smp_take,
    input  logic [SW-1:0]             smp_data,
    output logic                      fill_en,
    output logic [SW-1:0]             fill_data,
    output logic [IDX_W-1:0]          cur_idx,
    output logic [IDX_W-1:0]          pre_idx,
    output logic [IDX_W-1:0]          last_idx,
    output logic [LW-1:0]             remaining,
    output logic                      halted,
    output logic                      last_flag,
    output logic                      run_active,
    output logic                      ioc_evt,
    output logic                      last_evt
);
    import seq_pkg::*;

    localparam int DESC_SHIFT = 3;
    localparam logic [AW-1:0] CTL_OFS = AW'(4);

    seq_state_t st_q, st_n;
    logic          halted_q, halted_n;
    logic          celv_q, celv_n;
    logic          run_q, run_n;
    logic [AW-1:0] base_q;
    logic          ioc_f_q, ioc_f_n;
    logic          hold_f_q, hold_f_n;
    logic          ioc_q, ioc_n;
    logic          lend_q, lend_n;

    logic adv, ld_addr, ld_len, take_ok, fin_arm, zero_clr;
    logic at_last, final_take;
    logic [LW-1:0] rem;
    logic [AW-1:0] baddr;
    logic [LW-1:0] word_len;

    assign word_len = mem_rdata[LW-1:0];

    ring_ptrs #(.IDX_W(IDX_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .lvi_we(lvi_wr), .lvi_val(lvi_wdata[IDX_W-1:0]),
        .cur_idx(cur_idx), .pre_idx(pre_idx), .last_idx(last_idx),
        .cur_is_last(at_last)
    );

    buf_tracker #(.AW(AW), .LW(LW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr), .ld_addr_val({mem_rdata[AW-1:2], 2'b00}),
        .ld_len(ld_len), .ld_len_val(word_len),
        .take(take_ok), .rem(rem), .baddr(baddr), .final_take(final_take)
    );

    fill_gen #(.SW(SW)) u_fill (
        .clk(clk), .rst_n(rst_n), .take(take_ok), .take_data(smp_data),
        .arm(fin_arm), .arm_hold(hold_f_q), .disarm(zero_clr),
        .fill_on(fill_en), .fill_data(fill_data)
    );

    // next-state and strobe logic
    always_comb begin
        st_n     = st_q;
        halted_n = halted_q;
        celv_n   = celv_q;
        run_n    = run_q;
        ioc_f_n  = ioc_f_q;
        hold_f_n = hold_f_q;
        ioc_n    = 1'b0;
        lend_n   = 1'b0;
        adv      = 1'b0;
        ld_addr  = 1'b0;
        ld_len   = 1'b0;
        take_ok  = 1'b0;
        fin_arm  = 1'b0;
        zero_clr = 1'b0;
        if (run_wr) begin
            run_n = run_wdata;
            if (run_wdata) begin
                adv      = 1'b1;
                halted_n = 1'b0;
            end else begin
                halted_n = 1'b1;
                st_n     = S_IDLE;
            end
        end else if (lvi_wr && run_q && halted_q) begin
            adv      = 1'b1;
            halted_n = 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                end
                S_FETCH_ADDR: begin
                    if (mem_rvalid) begin
                        ld_addr = 1'b1;
                        st_n    = S_FETCH_CTL;
                    end
                end
                S_FETCH_CTL: begin
                    if (mem_rvalid) begin
                        ld_len   = 1'b1;
                        ioc_f_n  = mem_rdata[CTL_IOC_BIT];
                        hold_f_n = mem_rdata[CTL_HOLD_BIT];
                        if (word_len == '0) begin
                            if (at_last) begin
                                halted_n = 1'b1;
                                zero_clr = 1'b1;
                                st_n     = S_IDLE;
                            end else begin
                                adv = 1'b1;
                            end
                        end else begin
                            st_n = S_STREAM;
                        end
                    end
                end
                S_STREAM: begin
                    if (smp_take) begin
                        take_ok = 1'b1;
                        if (final_take) begin
                            ioc_n = ioc_f_q;
                            if (at_last) begin
                                lend_n   = 1'b1;
                                halted_n = 1'b1;
                                celv_n   = 1'b1;
                                fin_arm  = 1'b1;
                                st_n     = S_IDLE;
                            end else begin
                                adv = 1'b1;
                            end
                        end
                    end
                end
                default: st_n = S_IDLE;
            endcase
        end
        if (adv) begin
            st_n   = S_FETCH_ADDR;
            celv_n = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            halted_q <= 1'b1;
            celv_q   <= 1'b0;
            run_q    <= 1'b0;
            base_q   <= '0;
            ioc_f_q  <= 1'b0;
            hold_f_q <= 1'b0;
            ioc_q    <= 1'b0;
            lend_q   <= 1'b0;
        end else begin
            st_q     <= st_n;
            halted_q <= halted_n;
            celv_q   <= celv_n;
            run_q    <= run_n;
            ioc_f_q  <= ioc_f_n;
            hold_f_q <= hold_f_n;
            ioc_q    <= ioc_n;
            lend_q   <= lend_n;
            if (base_wr) begin
                base_q <= {base_wdata[AW-1:2], 2'b00};
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = (st_q == S_FETCH_ADDR) || (st_q == S_FETCH_CTL);
        mem_addr   = base_q + (AW'(cur_idx) << DESC_SHIFT)
                   + ((st_q == S_FETCH_CTL) ? CTL_OFS : '0);
        smp_ready  = (st_q == S_STREAM);
        smp_addr   = baddr;
        fill_en    = run_q && halted_q;
        remaining  = rem;
        halted     = halted_q;
        last_flag  = celv_q;
        run_active = run_q;
        ioc_evt    = ioc_q;
        last_evt   = lend_q;
    end

    // R3: a fetch only runs on a live channel
    assert_fetch_not_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !halted);
    // R7: the last-buffer pulse coincides with a halted, flagged channel
    assert_last_evt_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_evt |-> (halted && last_flag && !smp_ready));
    // R6: completion is a single-cycle pulse
    assert_ioc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_evt |=> !ioc_evt);
    // R10: fill never overlaps a fetch or a live buffer
    assert_fill_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (!mem_req && !smp_ready));
    // R8: an index write on a halted running channel restarts it
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvi_wr && run_active && halted && !run_wr) |=> (mem_req && !halted));
endmodule

// File: tb/sim_desc_ring_seq.sv
module sim_desc_ring_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        lvi_wr = 1'b0;
    logic [7:0]  lvi_wdata = '0;
    logic        run_wr = 1'b0;
    logic        run_wdata = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        smp_ready;
    logic [31:0] smp_addr;
    logic        smp_take = 1'b0;
    logic [15:0] smp_data = '0;
    logic        fill_en;
    logic [15:0] fill_data;
    logic [4:0]  cur_idx, pre_idx, last_idx;
    logic [15:0] remaining;
    logic        halted, last_flag, run_active, ioc_evt, last_evt;

    desc_ring_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .base_wr(base_wr), .base_wdata(base_wdata),
        .lvi_wr(lvi_wr), .lvi_wdata(lvi_wdata),
        .run_wr(run_wr), .run_wdata(run_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .smp_ready(smp_ready), .smp_addr(smp_addr),
        .smp_take(smp_take), .smp_data(smp_data),
        .fill_en(fill_en), .fill_data(fill_data),
        .cur_idx(cur_idx), .pre_idx(pre_idx), .last_idx(last_idx),
        .remaining(remaining), .halted(halted), .last_flag(last_flag),
        .run_active(run_active), .ioc_evt(ioc_evt), .last_evt(last_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic        auto_take = 1'b0;
    logic [15:0] sdata = 16'h0100;
    logic [15:0] last_given = '0;
    logic [31:0] dmem [logic [31:0]];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (dmem.exists(a)) return dmem[a];
        if (a[2]) return 32'h0000_0001;
        return 32'h0000_3000;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // reference model, updated at each rising edge
    int          m_st;
    logic        m_halt, m_celv, m_run, m_ioc, m_bup, m_buplast, m_iocevt, m_lvievt;
    logic [4:0]  m_civ, m_piv, m_lvi;
    logic [31:0] m_base, m_addr;
    logic [15:0] m_rem, m_last;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_halt = 1; m_celv = 0; m_run = 0; m_ioc = 0; m_bup = 0;
            m_buplast = 0; m_iocevt = 0; m_lvievt = 0;
            m_civ = 0; m_piv = 0; m_lvi = 0; m_base = 0; m_addr = 0; m_rem = 0; m_last = 0;
        end else begin
            logic [31:0] fa, wd;
            logic [4:0]  old_lvi;
            bit          adv;
            fa = m_base + 32'(m_civ) * 8 + ((m_st == 2) ? 32'd4 : 32'd0);
            wd = mem_word(fa);
            old_lvi = m_lvi;
            adv = 0;
            m_iocevt = 0;
            m_lvievt = 0;
            if (base_wr) m_base = base_wdata & 32'hFFFF_FFFC;
            if (lvi_wr) m_lvi = 5'(lvi_wdata % 32);
            if (run_wr) begin
                m_run = run_wdata;
                if (run_wdata) begin adv = 1; m_halt = 0; end
                else begin m_halt = 1; m_st = 0; end
            end else if (lvi_wr && m_run && m_halt) begin
                adv = 1; m_halt = 0;
            end else begin
                case (m_st)
                    1: if (mem_rvalid) begin m_addr = wd & 32'hFFFF_FFFC; m_st = 2; end
                    2: if (mem_rvalid) begin
                        m_ioc = wd[31]; m_bup = wd[30]; m_rem = wd[15:0];
                        if (m_rem == 0) begin
                            if (m_civ == old_lvi) begin m_halt = 1; m_buplast = 0; m_st = 0; end
                            else adv = 1;
                        end else m_st = 3;
                    end
                    3: if (smp_take) begin
                        m_last = smp_data;
                        m_addr = m_addr + 2;
                        if (m_rem == 1) begin
                            m_rem = 0;
                            m_iocevt = m_ioc;
                            if (m_civ == old_lvi) begin
                                m_lvievt = 1; m_halt = 1; m_celv = 1; m_buplast = m_bup; m_st = 0;
                            end else adv = 1;
                        end else m_rem = m_rem - 1;
                    end
                    default: ;
                endcase
            end
            if (adv) begin
                m_civ = m_piv; m_piv = m_piv + 5'd1; m_celv = 0; m_st = 1;
            end
        end
    end

    // per-cycle compare, memory responder and datapath take driver
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", "halted", 32'(halted), 32'(m_halt));
            chk("R3", "mem_req", 32'(mem_req), 32'(m_st == 1 || m_st == 2));
            if (mem_req)
                chk("R2", "mem_addr", mem_addr, m_base + 32'(m_civ) * 8 + ((m_st == 2) ? 32'd4 : 32'd0));
            chk("R11", "cur_idx", 32'(cur_idx), 32'(m_civ));
            chk("R11", "pre_idx", 32'(pre_idx), 32'(m_piv));
            chk("R2", "last_idx", 32'(last_idx), 32'(m_lvi));
            chk("R4", "smp_ready", 32'(smp_ready), 32'(m_st == 3));
            chk("R5", "remaining", 32'(remaining), 32'(m_rem));
            if (smp_ready) chk("R4", "smp_addr", smp_addr, m_addr);
            chk("R7", "last_flag", 32'(last_flag), 32'(m_celv));
            chk("R6", "ioc_evt", 32'(ioc_evt), 32'(m_iocevt));
            chk("R7", "last_evt", 32'(last_evt), 32'(m_lvievt));
            chk("R10", "fill_en", 32'(fill_en), 32'(m_run && m_halt));
            chk("R10", "fill_data", 32'(fill_data),
                32'((m_run && m_halt && m_buplast) ? m_last : 16'h0));
        end
        mem_rvalid = mem_req;
        mem_rdata  = mem_req ? mem_word(mem_addr) : 32'h0;
        smp_take   = auto_take && smp_ready;
        if (smp_take) begin
            smp_data   = sdata;
            last_given = sdata;
            sdata      = sdata + 16'd3;
        end
    end

    task automatic wr_base(input logic [31:0] v);
        @(negedge clk); base_wr = 1; base_wdata = v;
        @(negedge clk); base_wr = 0;
    endtask
    task automatic wr_lvi(input logic [7:0] v);
        @(negedge clk); lvi_wr = 1; lvi_wdata = v;
        @(negedge clk); lvi_wr = 0;
    endtask
    task automatic wr_run(input logic v);
        @(negedge clk); run_wr = 1; run_wdata = v;
        @(negedge clk); run_wr = 0;
    endtask
    task automatic wait_halt();
        for (int i = 0; i < 2000; i++) begin
            if (halted) break;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        dmem[32'h1000] = 32'h0000_2001; dmem[32'h1004] = 32'h8000_0003;
        dmem[32'h1008] = 32'h0000_2101; dmem[32'h100C] = 32'h0000_0002;
        dmem[32'h1010] = 32'h0000_2200; dmem[32'h1014] = 32'h0000_0000;
        dmem[32'h1018] = 32'h0000_2300; dmem[32'h101C] = 32'hC000_0001;
        dmem[32'h1020] = 32'h0000_2400; dmem[32'h1024] = 32'h0000_0001;
        dmem[32'h1028] = 32'h0000_2500; dmem[32'h102C] = 32'h4000_0000;
        dmem[32'h1030] = 32'h0000_2600; dmem[32'h1034] = 32'h0000_0014;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "halted after reset", 32'(halted), 32'd1);
        chk("R1", "indices after reset", {17'd0, cur_idx, pre_idx, last_idx}, 32'd0);
        chk("R1", "idle after reset", {29'd0, mem_req, smp_ready, fill_en}, 32'd0);

        // R2: base low bits dropped; last index 35 stored as 3
        wr_base(32'h0000_1003);
        wr_lvi(8'd35);
        chk("R2", "lvi modulo 32", 32'(last_idx), 32'd3);

        // R3/R6/R7/R9/R10: run through d0..d3 (d2 empty), end on hold policy
        auto_take = 1;
        wr_run(1);
        chk("R3", "run clears halt", 32'(halted), 32'd0);
        wait_halt();
        chk("R7", "ring end index", 32'(cur_idx), 32'd3);
        chk("R7", "last flag at ring end", 32'(last_flag), 32'd1);
        chk("R10", "fill holds last sample", 32'(fill_data), 32'(last_given));

        // R8/R9: restart by index write; d5 empty and last
        wr_lvi(8'd5);
        chk("R8", "index write restarts", {31'd0, halted}, 32'd0);
        wait_halt();
        chk("R9", "empty last halts at 5", 32'(cur_idx), 32'd5);
        chk("R9", "no last flag on empty end", 32'(last_flag), 32'd0);
        chk("R10", "fill zero after empty end", 32'(fill_data), 32'd0);

        // R8: index write while streaming only stores
        wr_lvi(8'd9);
        repeat (6) @(negedge clk);
        wr_lvi(8'd10);
        chk("R8", "no restart while live", 32'(cur_idx), 32'd6);
        chk("R8", "still streaming", 32'(smp_ready), 32'd1);
        // R3: stop mid-buffer
        wr_run(0);
        chk("R3", "stop halts", 32'(halted), 32'd1);
        chk("R3", "stop ends stream", {30'd0, smp_ready, fill_en}, 32'd0);
        wr_lvi(8'd2);
        chk("R8", "no restart with run clear", {31'd0, mem_req}, 32'd0);

        // R11: run through the wrap 7..31,0,1,2
        wr_run(1);
        wait_halt();
        chk("R11", "wrapped current", 32'(cur_idx), 32'd2);
        chk("R11", "wrapped prefetch", 32'(pre_idx), 32'd3);
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule